// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter controlled through four word-wide registers on a simple single-cycle memory-mapped bus. Software sets a reload value, turns the counter on, and chooses the count rate. The counter can advance on every core clock, or only on cycles where an external reference tick input is high. The reference tick is already synchronous and lasts one cycle. Each time the count passes through zero, the counter reloads, sets a sticky expiry flag and, if allowed, raises a one-cycle interrupt request for a downstream interrupt controller.

The bus is combinational on the read side: `bus_rdata` reflects the addressed register in the same cycle that `bus_sel` is high with `bus_wr` low. Register side effects (flag clearing, reloading) take place at the clock edge that ends the access. A reload value of zero gives a one-shot timer: the counter expires once and then switches itself off.

Top module: `systick_timer`

## Requirements
- R1: Byte offsets decode on address bits 3:2: 0x0 control, 0x4 reload, 0x8 current value, 0xC calibration; address bits 1:0 are ignored. In the control word, bit 0 is counter enable, bit 1 is interrupt enable, bit 2 is source select (1 = core clock, 0 = reference tick) and bit 16 is the expiry flag; all other bits read 0. After reset every register reads 0 except calibration.
- R2: A control write changes only bits 2:0; writing bit 16 has no effect on the flag.
- R3: A control read returns the current flag and clears it at the end of that access, unless an expiry occurs in the same cycle, in which case the flag stays 1.
- R4: When a control write sets enable while the counter is off, the current value is loaded from the reload register. The count then drops by one per step, so one period is reload+1 steps.
- R5: A step taken while the current value is 0 is an expiry: the flag becomes 1, and `irq_req` is high for exactly the following cycle when interrupt enable was 1 at the expiry.
- R6: On an expiry with a reload value of 0, the enable bit clears itself, so only one expiry occurs.
- R7: A write of any data to the current-value register reloads the counter from the reload register and clears the flag.
- R8: The current-value register reads 0 while enable is 0.
- R9: A control write that keeps enable at 1 but changes the source select restarts the count from the reload value.
- R10: The calibration register always reads 10000 (decimal), and writes to it have no effect.
- R11: With core source selected, the counter steps every clock; with reference source selected, it steps only in cycles where `ref_tick` is 1.
- R12: Clearing enable freezes the count. Enabling again reloads it from the reload register.
- R13: The reload and current-value registers hold 24 bits; bits 31:24 read 0 and are discarded on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ref_tick | input | 1 | Synchronous one-cycle reference tick |
| irq_req | output | 1 | One-cycle interrupt request on expiry |

## Verification
The difficult overlap is an expiry that lands in the same cycle as a bus access that also touches the flag or the count: a control read that would clear the flag, or a current-value or control write that would reload. The bench provokes this in two ways. Directed sequences read the control word or write the current value on every cycle across a short reload period, so one access must coincide with the wrap. A random phase with small reload values makes such coincidences common. Each outcome is judged against a cycle model in the bench, in which a set of the flag wins over a clear, and bus reloads take priority over the counter's own step.

// File: rtl/systick_pkg.sv
package systick_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int CNT_W    = 24;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    localparam logic [DATA_W-1:0] CAL_WORD = 32'd10000;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_CALIB   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic rd_ctrl;
        logic wr_reload;
        logic wr_current;
    } bus_strb_t;

    function automatic reg_sel_e word_of(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [2:0] w);
        ctrl_t c;
        c.en  = w[BIT_EN];
        c.ie  = w[BIT_IE];
        c.src = w[BIT_SRC];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_EN]   = c.en;
        w[BIT_IE]   = c.ie;
        w[BIT_SRC]  = c.src;
        w[BIT_FLAG] = flag;
        return w;
    endfunction

endpackage

// File: rtl/systick_bus_decode.sv
module systick_bus_decode
    import systick_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          rsel,
    output bus_strb_t         strb
);

    logic unused_low_addr;
    assign unused_low_addr = ^bus_addr[1:0];

    assign rsel = word_of(bus_addr);

    always_comb begin
        strb            = '0;
        strb.wr_ctrl    = bus_sel &&  bus_wr && (rsel == REG_CTRL);
        strb.rd_ctrl    = bus_sel && !bus_wr && (rsel == REG_CTRL);
        strb.wr_reload  = bus_sel &&  bus_wr && (rsel == REG_RELOAD);
        strb.wr_current = bus_sel &&  bus_wr && (rsel == REG_CURRENT);
    end

endmodule

// File: rtl/systick_step_gen.sv
module systick_step_gen (
    input  logic enable,
    input  logic core_src,
    input  logic ref_tick,
    output logic step
);

    always_comb begin
        if (!enable) begin
            step = 1'b0;
        end else if (core_src) begin
            step = 1'b1;
        end else begin
            step = ref_tick;
        end
    end

endmodule

// File: rtl/systick_core.sv
module systick_core
    import systick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_strb_t     strb,
    input  logic [2:0]    ctrl_wdata,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          step,
    output ctrl_t         ctrl_q,
    output logic          flag_q,
    output logic [CW-1:0] reload_q,
    output logic [CW-1:0] cur_q,
    output logic          expire,
    output logic          irq_q
);

    ctrl_t         ctrl_wr;
    ctrl_t         ctrl_d;
    logic          flag_d;
    logic [CW-1:0] cur_d;
    logic [CW-1:0] reload_d;
    logic          restart;
    logic          flag_clr;

    assign ctrl_wr  = ctrl_from_word(ctrl_wdata);
    assign expire   = step && (cur_q == '0);
    assign flag_clr = strb.rd_ctrl || strb.wr_current;
    assign restart  = strb.wr_ctrl && ctrl_wr.en &&
                      (!ctrl_q.en || (ctrl_wr.src != ctrl_q.src));

    always_comb begin
        cur_d = cur_q;
        if (step) begin
            cur_d = expire ? reload_q : cur_q - 1'b1;
        end
        if (restart || strb.wr_current) begin
            cur_d = reload_q;
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (expire && (reload_q == '0)) begin
            ctrl_d.en = 1'b0;
        end
        if (strb.wr_ctrl) begin
            ctrl_d = ctrl_wr;
        end
    end

    always_comb begin
        flag_d = flag_q;
        if (flag_clr) begin
            flag_d = 1'b0;
        end
        if (expire) begin
            flag_d = 1'b1;
        end
    end

    assign reload_d = strb.wr_reload ? cnt_wdata : reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
            cur_q    <= '0;
            reload_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            flag_q   <= flag_d;
            cur_q    <= cur_d;
            reload_q <= reload_d;
            irq_q    <= expire && ctrl_q.ie;
        end
    end

endmodule

// File: rtl/systick_read_mux.sv
module systick_read_mux
    import systick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  reg_sel_e      rsel,
    input  ctrl_t         ctrl_q,
    input  logic          flag_q,
    input  logic [CW-1:0] reload_q,
    input  logic [CW-1:0] cur_q,
    output logic [DW-1:0] rdata
);

    localparam int PAD_W = DW - CW;

    always_comb begin
        unique case (rsel)
            REG_CTRL:    rdata = ctrl_to_word(ctrl_q, flag_q);
            REG_RELOAD:  rdata = {{PAD_W{1'b0}}, reload_q};
            REG_CURRENT: rdata = ctrl_q.en ? {{PAD_W{1'b0}}, cur_q} : '0;
            REG_CALIB:   rdata = CAL_WORD;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/systick_timer.sv
module systick_timer
    import systick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              irq_req
);

    reg_sel_e      rsel;
    bus_strb_t     strb;
    ctrl_t         ctrl_q;
    logic          flag_q;
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cur_q;
    logic          step;
    logic          expire;
    logic          unused_hi_wdata;

    assign unused_hi_wdata = ^bus_wdata[DATA_W-1:CW];

    systick_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rsel     (rsel),
        .strb     (strb)
    );

    systick_step_gen u_step (
        .enable   (ctrl_q.en),
        .core_src (ctrl_q.src),
        .ref_tick (ref_tick),
        .step     (step)
    );

    systick_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .strb       (strb),
        .ctrl_wdata (bus_wdata[2:0]),
        .cnt_wdata  (bus_wdata[CW-1:0]),
        .step       (step),
        .ctrl_q     (ctrl_q),
        .flag_q     (flag_q),
        .reload_q   (reload_q),
        .cur_q      (cur_q),
        .expire     (expire),
        .irq_q      (irq_req)
    );

    systick_read_mux #(.CW(CW), .DW(DATA_W)) u_rd (
        .rsel     (rsel),
        .ctrl_q   (ctrl_q),
        .flag_q   (flag_q),
        .reload_q (reload_q),
        .cur_q    (cur_q),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/systick_checker.sv
module systick_checker
    import systick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_req,
    input logic              en,
    input logic              ie,
    input logic              flag,
    input logic              expire,
    input logic [CW-1:0]     reload,
    input logic [CW-1:0]     cur
);

    logic rd_ctrl, wr_ctrl, rd_cur, wr_cur, rd_cal;
    assign rd_ctrl = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd0);
    assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr[3:2] == 2'd0);
    assign rd_cur  = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd2);
    assign wr_cur  = bus_sel &&  bus_wr && (bus_addr[3:2] == 2'd2);
    assign rd_cal  = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd3);

    AST_FLAG_NOT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !expire && !flag) |=> !flag); // R2

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !expire) |=> !flag); // R3

    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[0] && !en) |=> (cur == $past(reload))); // R4

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> flag); // R5

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(ie)); // R5

    AST_ZERO_RELOAD_STOPS: assert property (@(posedge clk) disable iff (rst)
        (expire && (reload == '0) && !wr_ctrl) |=> !en); // R6

    AST_CUR_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        (rd_cur && !en) |-> (bus_rdata == '0)); // R8

    AST_CAL_CONST: assert property (@(posedge clk) disable iff (rst)
        rd_cal |-> (bus_rdata == 32'd10000)); // R10

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_ctrl && !wr_cur) |=> (cur == $past(cur))); // R12

endmodule

bind systick_timer systick_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .en        (ctrl_q.en),
    .ie        (ctrl_q.ie),
    .flag      (flag_q),
    .expire    (expire),
    .reload    (reload_q),
    .cur       (cur_q)
);

// File: tb/tb_systick_timer.sv
module tb_systick_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    systick_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq_req   (irq_req)
    );

    // Bench model of the requirements
    logic        m_en, m_ie, m_src, m_flag, m_irq;
    logic [23:0] m_rel, m_cur;

    task automatic model_reset();
        m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        m_rel = '0; m_cur = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};   // R1
            2'd1: return {8'd0, m_rel};                              // R13
            2'd2: return m_en ? {8'd0, m_cur} : 32'd0;               // R8
            default: return 32'd10000;                               // R10
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a[3:2])
            2'd0: return "R3";
            2'd1: return "R13";
            2'd2: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step(input logic s, input logic w, input logic [3:0] a,
                              input logic [31:0] d, input logic t);
        logic step, exp_now, wctl, rctl, wrel, wcur;
        logic n_en, n_ie, n_src, n_flag;
        logic [23:0] n_cur, n_rel;
        step    = m_en && (m_src || t);              // R11
        exp_now = step && (m_cur == 0);              // R5
        wctl = s &&  w && a[3:2] == 2'd0;
        rctl = s && !w && a[3:2] == 2'd0;
        wrel = s &&  w && a[3:2] == 2'd1;
        wcur = s &&  w && a[3:2] == 2'd2;
        n_en = m_en; n_ie = m_ie; n_src = m_src; n_flag = m_flag;
        n_cur = m_cur; n_rel = m_rel;
        if (step) n_cur = exp_now ? m_rel : m_cur - 24'd1;
        if (exp_now && m_rel == 0) n_en = 0;         // R6
        if (rctl || wcur) n_flag = 0;                // R3 R7
        if (exp_now) n_flag = 1;
        if (wctl) begin                              // R2
            n_en = d[0]; n_ie = d[1]; n_src = d[2];
            if (d[0] && (!m_en || d[2] != m_src)) n_cur = m_rel;   // R4 R9 R12
        end
        if (wrel) n_rel = d[23:0];
        if (wcur) n_cur = m_rel;                     // R7
        m_irq  = exp_now && m_ie;
        m_en = n_en; m_ie = n_ie; m_src = n_src; m_flag = n_flag;
        m_cur = n_cur; m_rel = n_rel;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic t, input string tag);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ref_tick = t;
        #1;
        check("R5", "irq_req", {31'd0, irq_req}, {31'd0, m_irq});
        if (s && !w)
            check(tag != "" ? tag : tag_of(a), "read data", bus_rdata, model_read(a));
        @(posedge clk);
        model_step(s, w, a, d, t);
    endtask

    task automatic idle(input int n, input logic t, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'd0, t, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1, 1, a, d, 0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1, 0, a, 32'd0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // Reset state and register map
        rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");
        rd(4'hE, "R1");                               // low address bits ignored
        wr(4'hC, 32'h1234, "R10"); rd(4'hC, "R10");
        wr(4'h4, 32'hFFFF_FFFF, "R13"); rd(4'h4, "R13");

        // Period reload+1 with core clock and interrupt
        wr(4'h4, 32'd3, "R4");
        wr(4'h0, 32'h7, "R4");
        for (int i = 0; i < 10; i++) rd(4'h8, "R4");
        idle(6, 0, "R5");

        // Control read coinciding with an expiry
        for (int i = 0; i < 9; i++) rd(4'h0, "R3");

        // Flag bit not writable
        wr(4'h0, 32'h0, "R2"); rd(4'h0, "R2");
        wr(4'h0, 32'h0001_0000, "R2"); rd(4'h0, "R2");

        // Current-value write reloads and clears flag, also against an expiry
        wr(4'h4, 32'd2, "R7"); wr(4'h0, 32'h5, "R7");
        for (int i = 0; i < 7; i++) begin
            cyc(1, 1, 4'h8, 32'hDEAD_BEEF, 0, "R7");
            rd(4'h0, "R7"); rd(4'h8, "R7");
        end

        // Zero reload: one expiry, then off
        wr(4'h4, 32'd0, "R6"); wr(4'h0, 32'h0, "R6"); wr(4'h0, 32'h7, "R6");
        for (int i = 0; i < 5; i++) rd(4'h0, "R6");
        idle(4, 0, "R6");

        // Reference tick source
        wr(4'h4, 32'd2, "R11"); wr(4'h0, 32'h3, "R11");
        for (int i = 0; i < 14; i++) cyc(1, 0, 4'h8, 32'd0, (i % 3) == 1, "R11");

        // Source change while running restarts the count
        wr(4'h4, 32'd9, "R9"); wr(4'h0, 32'h7, "R9");
        idle(4, 0, "R9");
        wr(4'h0, 32'h3, "R9"); rd(4'h8, "R9");
        wr(4'h0, 32'h7, "R9"); rd(4'h8, "R9");

        // Disable freezes, reads 0; re-enable reloads
        idle(3, 0, "R12");
        wr(4'h0, 32'h4, "R12"); rd(4'h8, "R8");
        idle(5, 0, "R12");
        wr(4'h0, 32'h5, "R12"); rd(4'h8, "R12");

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [3:0]  a;
            logic [31:0] d;
            r = $urandom_range(0, 99);
            a = {$urandom_range(0, 3) == 0 ? 2'd0 : 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            case (a[3:2])
                2'd0: d = {$urandom_range(0, 1) ? 16'h0001 : 16'h0, 13'd0,
                           3'($urandom_range(0, 7)) | ($urandom_range(0, 3) != 0 ? 3'd1 : 3'd0)};
                2'd1: d = $urandom_range(0, 9) == 0 ? $urandom : 32'($urandom_range(0, 6));
                default: d = $urandom;
            endcase
            if (r < 55) cyc(0, 0, 4'h0, 32'd0, $urandom_range(0, 2) == 0, "");
            else if (r < 80) cyc(1, 0, a, 32'd0, $urandom_range(0, 2) == 0, "");
            else cyc(1, 1, a, d, $urandom_range(0, 2) == 0, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule